// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (I2C, block-write)

This block is the configuration port of a clock generator. It sits on a two-wire I2C bus running at up to 100 kbit/s and holds six 8-bit configuration bytes. The bytes are presented in parallel to the rest of the chip at all times. SCL and SDA are sampled with the system clock. SDA is driven only low, through an output enable that the pad turns into an open-drain pull-down.

The host programs the block with one fixed transaction shape. After the write address it sends two header bytes, a command code and a byte count. The slave acknowledges both and then discards them. Data then fills the registers in strict ascending order from byte 0, and the host may stop after any whole byte. A read returns a count byte first, then the register contents starting at byte 0. There is no random access in either direction.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, `cfg_bytes` holds configuration byte k at bits [8k+7:8k]. Byte 0 is 0x00 and bytes 1 to 5 are 0xFF.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start seen at any point, including inside a transfer, begins a new address phase. Bytes already committed stay committed.
- R3: The slave acknowledges the 8-bit address bytes 0xD2 (write) and 0xD3 (read) and no others. After any other address it leaves SDA released and ignores every later byte until the next start.
- R4: In a write, the two bytes that follow the address are acknowledged and change no configuration byte.
- R5: Write data bytes are acknowledged and stored in ascending order: the first data byte goes to byte 0, the sixth to byte 5. Each stored value appears on `cfg_bytes`.
- R6: A stop after any complete byte ends the write. Bytes received before the stop keep their new values, and the bytes not reached keep their previous values.
- R7: A seventh or later data byte in one write is not acknowledged and changes no configuration byte.
- R8: A read sends the count value 0x06 first, then bytes 0 to 5, each most significant bit first. While the master acknowledges, the slave continues with the next byte.
- R9: When the master does not acknowledge a read byte, the slave releases SDA. It drives nothing more until the next start, even if SCL keeps toggling.
- R10: `sda_oe` changes value only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line as seen at the pad |
| sda_in | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_bytes | output | 48 | Configuration bytes 0..5, byte k at [8k+7:8k] |

## Verification
On every cycle the assertions check four things. The data-line enable only moves while the synchronized clock is low. Every register write falls in the valid slot range and is followed by an acknowledge. The configuration bus holds still unless a write occurs. Start and stop both leave SDA released. The transaction-level behaviour can only be shown by the bench scenarios: which address values are accepted, that the header bytes are discarded, how a write truncated at every length lands, the rejection of surplus bytes, the read-back order with its leading count, the silence after a master not-acknowledge, and a repeated start that cuts into a transfer.

// File: rtl/clkcfg_i2c_pkg.sv
package clkcfg_i2c_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECV,
    PH_ACK,
    PH_SEND,
    PH_MACK,
    PH_SKIP
  } phase_e;

  // Power-up contents: the first byte clear, the rest all ones.
  function automatic logic [7:0] reg_reset_value(input int unsigned idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction

  // Full 8-bit address byte for a 7-bit device address and a direction bit.
  function automatic logic [7:0] addr_byte(input logic [6:0] dev, input logic rnw);
    return {dev, rnw};
  endfunction

  // True when a received byte number (address = 0) lands in a register slot.
  function automatic logic in_data_slot(input int unsigned num, input int unsigned hdr,
                                        input int unsigned nregs);
    return (num > hdr) && (num <= hdr + nregs);
  endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  // Idle bus is high on both lines, so the pipes reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;

endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
  import clkcfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] cfg_flat
);

  localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_REGS);

  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= reg_reset_value(g);
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        regs[g] <= wr_data;
      end
    end
    assign cfg_flat[g*8 +: 8] = regs[g];
  end

  // Indices past the last slot read as all ones (released bus).
  always_comb begin
    rd_data = 8'hFF;
    if (rd_idx < IDX_LIMIT) begin
      rd_data = regs[rd_idx];
    end
  end

endmodule

// File: rtl/clkcfg_byte_engine.sv
module clkcfg_byte_engine
  import clkcfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_REGS  = 6,
  parameter int         HDR_BYTES = 2,
  parameter int         IDX_W     = 3,
  parameter int         CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             byte_end,
  output logic             ack_slot
);

  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] SLOT_LAST  = CNT_W'(HDR_BYTES + NUM_REGS);
  localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] IDX_NONE   = IDX_W'(NUM_REGS);
  localparam logic [7:0]       COUNT_BYTE = 8'(NUM_REGS);

  phase_e           phase;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sh;
  logic [7:0]       tx_sh;
  logic             rd_mode;
  logic             mack;
  logic [CNT_W-1:0] rx_num;
  logic [CNT_W-1:0] tx_num;
  logic [CNT_W-1:0] slot_off;
  logic             addr_phase;
  logic             wr_hit;
  logic             rd_hit;
  logic             take;

  assign addr_phase = (rx_num == '0);
  assign wr_hit     = (rx_sh == addr_byte(DEV_ADDR, 1'b0));
  assign rd_hit     = (rx_sh == addr_byte(DEV_ADDR, 1'b1));
  assign byte_end   = (phase == PH_RECV) && scl_fall && (bit_cnt == 4'd8);
  assign take       = addr_phase ? (wr_hit | rd_hit) : (rx_num <= SLOT_LAST);
  assign slot_off   = rx_num - HDR_LAST - CNT_W'(1);
  assign ack_slot   = (phase == PH_ACK);

  assign wr_en   = byte_end && in_data_slot(int'(rx_num), HDR_BYTES, NUM_REGS);
  assign wr_idx  = slot_off[IDX_W-1:0];
  assign wr_data = rx_sh;
  assign rd_idx  = (tx_num < TX_LAST) ? tx_num[IDX_W-1:0] : IDX_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rd_mode <= 1'b0;
      mack    <= 1'b1;
      rx_num  <= '0;
      tx_num  <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      phase   <= PH_RECV;
      bit_cnt <= '0;
      rx_num  <= '0;
      rd_mode <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (phase)
        PH_RECV: begin
          if (scl_rise && (bit_cnt < 4'd8)) begin
            rx_sh   <= {rx_sh[6:0], sda_q};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_end) begin
            if (take) begin
              phase  <= PH_ACK;
              sda_oe <= 1'b1;
              if (addr_phase) rd_mode <= rd_hit;
            end else begin
              phase <= PH_SKIP;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              tx_sh  <= COUNT_BYTE;
              sda_oe <= ~COUNT_BYTE[7];
              tx_num <= '0;
              phase  <= PH_SEND;
            end else begin
              sda_oe <= 1'b0;
              rx_num <= rx_num + CNT_W'(1);
              phase  <= PH_RECV;
            end
          end
        end
        PH_SEND: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              phase  <= PH_MACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              sda_oe  <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            mack <= sda_q;
          end else if (scl_fall) begin
            if (!mack) begin
              tx_sh   <= rd_data;
              sda_oe  <= ~rd_data[7];
              bit_cnt <= '0;
              if (tx_num < TX_LAST) tx_num <= tx_num + CNT_W'(1);
              phase   <= PH_SEND;
            end else begin
              phase <= PH_SKIP;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 6,
  parameter int         HDR_BYTES   = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_bytes
);

  localparam int IDX_W = $clog2(NUM_REGS + 1);
  localparam int CNT_W = $clog2(HDR_BYTES + NUM_REGS + 2);

  logic             scl_q;
  logic             sda_q;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_data;
  logic             byte_end;
  logic             ack_slot;

  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  clkcfg_byte_engine #(
    .DEV_ADDR  (DEV_ADDR),
    .NUM_REGS  (NUM_REGS),
    .HDR_BYTES (HDR_BYTES),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .byte_end  (byte_end),
    .ack_slot  (ack_slot)
  );

  clkcfg_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cfg_flat (cfg_bytes)
  );

endmodule

// File: rtl/clkcfg_i2c_checker.sv
module clkcfg_i2c_checker #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_q,
  input logic                  sda_oe,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] cfg_bytes
);

  // R10: the enable never moves while the sampled clock is high
  a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

  // R5: every commit targets a real slot
  a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));

  // R5: a committed byte is acknowledged right after
  a_r5_write_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R6: configuration only changes through a write
  a_r6_cfg_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_bytes));

  // R2: start and stop leave the data line released
  a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checker #(
  .NUM_REGS (NUM_REGS),
  .IDX_W    (IDX_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_q     (scl_q),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .cfg_bytes (cfg_bytes)
);

// File: tb/clkcfg_i2c_slave_test.sv
module clkcfg_i2c_slave_test;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic        sda_line;
  logic [47:0] cfg_bytes;

  int n_vec = 0;
  int n_bad = 0;
  int oe_viol = 0;
  logic prev_oe = 1'b0;
  logic finished = 1'b0;
  logic [7:0] model [6];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  clkcfg_i2c_slave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .cfg_bytes (cfg_bytes)
  );

  // R10 monitor: enable changes while the raw clock line is high
  always @(posedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl) oe_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] model_flat();
    logic [47:0] f;
    for (int k = 0; k < 6; k++) f[k*8 +: 8] = model[k];
    return f;
  endfunction

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 59) ^ (seed * 29) ^ 8'hA5);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(2*Q);
      scl = 1'b0;   tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    sda_m = master_ack ? 1'b0 : 1'b1; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // Write: address, two header bytes, then ndata data bytes, then stop
  task automatic do_write(input int ndata, input int seed);
    logic a;
    bus_start();
    send_byte(8'hD2, a);             chk("R3 write address ack", a, 1'b1);
    send_byte(8'(seed ^ 8'h5A), a);  chk("R4 command byte ack", a, 1'b1);
    send_byte(8'(seed ^ 8'h33), a);  chk("R4 count byte ack", a, 1'b1);
    for (int k = 0; k < ndata; k++) begin
      send_byte(pat(k, seed), a);
      if (k < 6) begin
        chk("R5 data byte ack", a, 1'b1);
        model[k] = pat(k, seed);
      end else begin
        chk("R7 surplus byte not acked", a, 1'b0);
      end
    end
    bus_stop();
    tick(Q);
    chk("R6 cfg after write", cfg_bytes, model_flat());
  endtask

  // Read nbytes data bytes, NACK the last, then check the line stays released
  task automatic do_read(input int nbytes);
    logic a;
    logic [7:0] b;
    logic quiet;
    bus_start();
    send_byte(8'hD3, a); chk("R3 read address ack", a, 1'b1);
    recv_byte(nbytes > 0, b); chk("R8 count byte", b, 8'h06);
    for (int k = 0; k < nbytes; k++) begin
      recv_byte(k < nbytes - 1, b);
      chk("R8 read data byte", b, model[k]);
    end
    quiet = 1'b1;
    for (int i = 0; i < 9; i++) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      if (sda_line !== 1'b1) quiet = 1'b0;
      tick(Q);
      scl = 1'b0; tick(Q);
    end
    chk("R9 released after master nack", quiet, 1'b1);
    bus_stop();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] bad_addr [10];
    for (int k = 0; k < 6; k++) model[k] = (k == 0) ? 8'h00 : 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R1 reset contents", cfg_bytes, 48'hFFFF_FFFF_FF00);
    do_read(6);

    // Write lengths 0..7: stop after every possible byte, then read back
    for (int len = 0; len <= 7; len++) begin
      do_write(len, len + 1);
      do_read(6);
    end
    do_read(2);

    // Rejected addresses: every single-bit corruption except the R/W bit
    for (int b = 1; b < 8; b++) bad_addr[b-1] = 8'hD2 ^ 8'(1 << b);
    bad_addr[7] = 8'h00;
    bad_addr[8] = 8'hFF;
    bad_addr[9] = 8'hA4;
    for (int i = 0; i < 10; i++) begin
      bus_start();
      send_byte(bad_addr[i], a); chk("R3 foreign address nack", a, 1'b0);
      for (int k = 0; k < 3; k++) begin
        send_byte(8'h00, a); chk("R3 bytes ignored after mismatch", a, 1'b0);
      end
      bus_stop();
      tick(Q);
      chk("R3 cfg unchanged after mismatch", cfg_bytes, model_flat());
    end

    // Repeated start after a mismatch, without a stop
    bus_start();
    send_byte(8'h52, a); chk("R2 mismatch before restart", a, 1'b0);
    bus_start();
    send_byte(8'hD2, a); chk("R2 address after restart", a, 1'b1);
    send_byte(8'h00, a);
    send_byte(8'h06, a);
    send_byte(8'hC3, a); chk("R2 data ack after restart", a, 1'b1);
    model[0] = 8'hC3;
    // Restart in the middle of the write: byte 0 stays, new write starts over
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h06, a);
    send_byte(8'h7E, a); model[0] = 8'h7E;
    send_byte(8'h81, a); model[1] = 8'h81;
    bus_stop();
    tick(Q);
    chk("R2 cfg after restarted writes", cfg_bytes, model_flat());
    do_read(6);

    chk("R10 enable moved only with SCL low", oe_viol, 0);
    finish_run();
  end

endmodule